// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the internal word address for every beat of a four-word burst. Each enabled clock either captures a fresh external address or steps to the next beat. A single control line makes that choice: low loads, high advances. When it steps, only the two least significant address bits move. The bits above them hold the value captured at load time, so a burst never leaves its aligned four-word block.

A static order input picks how the low bits travel. In linear order they count up modulo four from the starting position. In interleaved order they are the starting bits XORed with the beat number. An active-low clock enable freezes all state and ignores every other synchronous input. A synchronous reset returns the sequencer to address zero, beat zero, and it acts even while the clock enable is inactive.

Internally a four-state machine tracks the beat: `BEAT0`, `BEAT1`, `BEAT2` and `BEAT3`. Its transitions are:
- `LOAD`: from any state to `BEAT0`.
- `STEP`: `BEAT0`→`BEAT1`→`BEAT2`→`BEAT3`, then a wrap from `BEAT3` back to `BEAT0`.
- `HOLD`: any state to itself.
- `RESET`: any state to `BEAT0`.

Top module: `burst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `cur_addr` = 0 and `beat_idx` = 0.
- R2: At a rising edge with `cke_n` = 0 and `advance` = 0, `cur_addr` takes `ext_addr` (with zero beat offset) and `beat_idx` becomes 0.
- R3: With `order_ilv` = 0 (linear), `cur_addr[1:0]` equals (start low bits + `beat_idx`) mod 4.
- R4: With `order_ilv` = 1 (interleaved), `cur_addr[1:0]` equals the start low bits XOR `beat_idx`.
- R5: At a rising edge with `cke_n` = 0 and `advance` = 1, `cur_addr[AW-1:2]` does not change.
- R6: An advance from `beat_idx` = 3 returns `beat_idx` to 0 and the low bits to the start position, with no carry into the upper bits.
- R7: At a rising edge with `cke_n` = 1, `advance` and `ext_addr` are ignored, and `cur_addr` and `beat_idx` keep their values.
- R8: Reset takes effect even when `cke_n` = 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cke_n | input | 1 | Clock enable, active low; high freezes all state |
| advance | input | 1 | 1 = step to next beat, 0 = load `ext_addr` |
| ext_addr | input | AW | External word address captured on load |
| order_ilv | input | 1 | Static order select: 0 linear, 1 interleaved |
| cur_addr | output | AW | Address of the current beat |
| beat_idx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
Two functions can fall in the same cycle. The first is a freeze (`cke_n` high) together with a load request that carries a new address, or with a step from `BEAT3` that would otherwise wrap. The second is reset arriving while the enable is inactive. The bench drives each combination on purpose and also in a long random run. After every edge it compares `cur_addr` and `beat_idx` with a behavioural model in which hold beats load and step, and reset beats hold.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int unsigned LOW_W = 2;
    localparam int unsigned BEATS = 1 << LOW_W;

    typedef enum logic [1:0] {
        BEAT0 = 2'd0,
        BEAT1 = 2'd1,
        BEAT2 = 2'd2,
        BEAT3 = 2'd3
    } beat_state_e;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_STEP = 2'd2
    } beat_op_e;

endpackage

// File: rtl/burst_beat_fsm.sv
module burst_beat_fsm
    import burst_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cke_n,
    input  logic                 advance,
    output beat_op_e             op,
    output logic [LOW_W-1:0]     beat_idx
);

    beat_state_e state_q;
    beat_state_e state_d;

    // operation decode: hold dominates load/step
    always_comb begin
        if (cke_n)        op = OP_HOLD;
        else if (advance) op = OP_STEP;
        else              op = OP_LOAD;
    end

    // transitions LOAD / STEP / HOLD
    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_HOLD: state_d = state_q;
            OP_LOAD: state_d = BEAT0;
            OP_STEP: begin
                unique case (state_q)
                    BEAT0: state_d = BEAT1;
                    BEAT1: state_d = BEAT2;
                    BEAT2: state_d = BEAT3;
                    BEAT3: state_d = BEAT0;
                    default: state_d = BEAT0;
                endcase
            end
            default: state_d = state_q;
        endcase
    end

    // state register; RESET wins over HOLD
    always_ff @(posedge clk) begin
        if (rst) state_q <= BEAT0;
        else     state_q <= state_d;
    end

    // output process
    always_comb begin
        unique case (state_q)
            BEAT0: beat_idx = 2'd0;
            BEAT1: beat_idx = 2'd1;
            BEAT2: beat_idx = 2'd2;
            BEAT3: beat_idx = 2'd3;
            default: beat_idx = 2'd0;
        endcase
    end

    a_r8_reset_overrides_hold: assert property (@(posedge clk)
        rst |=> beat_idx == 2'd0);

    a_r7_freeze_beat: assert property (@(posedge clk) disable iff (rst)
        cke_n |=> $stable(beat_idx));

    a_r2_load_to_beat0: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && !advance) |=> beat_idx == 2'd0);

    a_r6_wrap_to_beat0: assert property (@(posedge clk) disable iff (rst)
        (!cke_n && advance && beat_idx == 2'd3) |=> beat_idx == 2'd0);

endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  logic                 clk,
    input  logic                 rst,
    input  beat_op_e             op,
    input  logic [AW-1:0]        ext_addr,
    output logic [AW-LOW_W-1:0]  upper,
    output logic [LOW_W-1:0]     start_low
);

    logic [AW-1:0] start_q;

    always_ff @(posedge clk) begin
        if (rst)                 start_q <= '0;
        else if (op == OP_LOAD)  start_q <= ext_addr;
    end

    assign upper     = start_q[AW-1:LOW_W];
    assign start_low = start_q[LOW_W-1:0];

    a_r1_reset_clears_start: assert property (@(posedge clk)
        rst |=> (upper == '0 && start_low == '0));

    a_r5_upper_fixed_on_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP) |=> $stable(upper));

    a_r2_upper_from_ext: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> upper == $past(ext_addr[AW-1:LOW_W]));

endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
    import burst_seq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  beat_op_e             op,
    input  logic [LOW_W-1:0]     start_low,
    input  logic [LOW_W-1:0]     beat_idx,
    input  logic                 order_ilv,
    output logic [LOW_W-1:0]     low
);

    logic [LOW_W-1:0] lin_low;
    logic [LOW_W-1:0] ilv_low;

    assign lin_low = start_low + beat_idx;

    for (genvar b = 0; b < LOW_W; b++) begin : g_ilv_bit
        assign ilv_low[b] = start_low[b] ^ beat_idx[b];
    end

    assign low = order_ilv ? ilv_low : lin_low;

    a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && !order_ilv) |=> (order_ilv || low == $past(low) + 2'd1));

    a_r4_ilv_invariant: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && order_ilv) |=> (!order_ilv || (low ^ beat_idx) == $past(low ^ beat_idx)));

    a_r6_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && beat_idx == 2'd3) |=> low == start_low);

endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cke_n,
    input  logic           advance,
    input  logic [AW-1:0]  ext_addr,
    input  logic           order_ilv,
    output logic [AW-1:0]  cur_addr,
    output logic [1:0]     beat_idx
);

    beat_op_e             op;
    logic [AW-LOW_W-1:0]  upper;
    logic [LOW_W-1:0]     start_low;
    logic [LOW_W-1:0]     low;

    burst_beat_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .cke_n    (cke_n),
        .advance  (advance),
        .op       (op),
        .beat_idx (beat_idx)
    );

    burst_start_reg #(.AW(AW)) u_start (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .ext_addr  (ext_addr),
        .upper     (upper),
        .start_low (start_low)
    );

    burst_low_gen u_low (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .start_low (start_low),
        .beat_idx  (beat_idx),
        .order_ilv (order_ilv),
        .low       (low)
    );

    assign cur_addr = {upper, low};

    a_r7_freeze_addr: assert property (@(posedge clk) disable iff (rst)
        (cke_n && $stable(order_ilv)) |=> $stable(cur_addr));

endmodule

// File: tb/burst_seq_bench.sv
`timescale 1ns/1ps
module burst_seq_bench;
    localparam int unsigned AW = 18;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke_n = 1'b1;
    logic          advance = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic          order_ilv = 1'b0;
    logic [AW-1:0] cur_addr;
    logic [1:0]    beat_idx;

    int vectors = 0;
    int misses  = 0;

    logic [AW-1:0] m_base = '0;
    int            m_beat = 0;

    always #2 clk = ~clk;

    burst_seq #(.AW(AW)) u_burst_seq (
        .clk(clk), .rst(rst), .cke_n(cke_n), .advance(advance),
        .ext_addr(ext_addr), .order_ilv(order_ilv),
        .cur_addr(cur_addr), .beat_idx(beat_idx)
    );

    function automatic logic [AW-1:0] model_addr();
        logic [1:0] s;
        logic [1:0] b;
        logic [1:0] l;
        s = m_base[1:0];
        b = 2'(m_beat);
        l = order_ilv ? (s ^ b) : 2'((int'(s) + m_beat) % 4);
        return {m_base[AW-1:2], l};
    endfunction

    task automatic compare(input string tag);
        logic [AW-1:0] ea;
        ea = model_addr();
        vectors++;
        if (cur_addr !== ea || beat_idx !== 2'(m_beat)) begin
            misses++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     tag, cur_addr, beat_idx, ea, m_beat);
        end
    endtask

    task automatic cycle(input logic r, input logic ce_n, input logic adv,
                         input logic [AW-1:0] a, input logic ilv, input string tag);
        rst = r; cke_n = ce_n; advance = adv; ext_addr = a; order_ilv = ilv;
        @(posedge clk);
        if (r) begin
            m_base = '0; m_beat = 0;
        end else if (!ce_n) begin
            if (!adv) begin m_base = a; m_beat = 0; end
            else m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(4 * 100000);
        misses++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        @(negedge clk);
        cycle(1, 1, 0, '0, 0, "R1");
        cycle(1, 0, 1, 18'h3ffff, 0, "R1");
        // R2 load then R3 linear burst from start 2: 2,3,0,1 then wrap R6
        cycle(0, 0, 0, 18'h1234e, 0, "R2");
        for (int i = 0; i < 3; i++) cycle(0, 0, 1, 18'h0, 0, "R3");
        cycle(0, 0, 1, 18'h0, 0, "R6");
        cycle(0, 0, 1, 18'h0, 0, "R5");
        // R4 interleaved from start 1: 1,0,3,2
        cycle(0, 0, 0, 18'h2aaa5, 1, "R2");
        for (int i = 0; i < 3; i++) cycle(0, 0, 1, 18'h0, 1, "R4");
        cycle(0, 0, 1, 18'h0, 1, "R6");
        // R6 no carry at top of address space
        cycle(0, 0, 0, 18'h3ffff, 0, "R2");
        for (int i = 0; i < 4; i++) cycle(0, 0, 1, 18'h0, 0, "R6");
        // R7 hold with load request carrying a new address
        cycle(0, 0, 1, 18'h0, 0, "R3");
        cycle(0, 1, 0, 18'h15555, 0, "R7");
        cycle(0, 1, 1, 18'h0, 0, "R7");
        cycle(0, 0, 1, 18'h0, 0, "R7");
        cycle(0, 0, 1, 18'h0, 0, "R6");
        cycle(0, 1, 1, 18'h0, 0, "R7");
        // R8 reset while frozen
        cycle(1, 1, 1, 18'h0, 0, "R8");
        cycle(0, 1, 0, 18'h3c3c3, 1, "R7");
        // random mix
        for (int i = 0; i < 2000; i++) begin
            logic [AW-1:0] ra;
            ra = AW'($urandom);
            cycle(($urandom % 50) == 0, ($urandom % 4) == 0, ($urandom % 5) != 0,
                  ra, ((i / 200) % 2) == 1, "R3/R4 random");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule